// File: doc/BRIEF.md
# Shared-Slave Bus Arbiter with Parking Policy

This block decides which of up to six bus masters owns a single shared slave port. Every cycle it looks at the request line and the end-of-burst flag of each master. It returns a registered one-hot grant vector. Configuration inputs set the arbitration scheme (rotating or priority-ordered) and a slot length that lets a long burst be cut short. They also choose which master, if any, stays parked on the slave while nobody requests it.

A master keeps the slave while it holds its request and has not flagged the final beat of its burst. A waiting master can take the slave earlier only when the current owner has used up its slot. When all requests fall away, the grant moves to the parked master chosen by the idle policy. The data path, address decoding and configuration storage sit outside this block.

Top module: `bus_slot_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the grant vector is all zeros.
- R2: The grant is registered and is zero or one-hot: inputs sampled at a clock edge set the grant shown after that edge.
- R3: With `arb_sel` at 0, 2 or 3 (rotating mode), the winner is the first requesting master found when scanning upward, with wrap, from the index one above the most recently arbitrated master. Before any grant, the scan starts at master 0.
- R4: With `arb_sel` at 1 (priority mode), master i's priority is `prio_word[4*i+1 : 4*i]`, and the requesting master with the largest value wins.
- R5: In priority mode, masters that tie on the largest value resolve to the lowest index.
- R6: An arbitrated owner keeps the grant unchanged while its request is high and its `last_beat` bit is low, unless R7 applies.
- R7: When `slot_len` is non-zero, the owner has held the grant for `slot_len` cycles, and another master requests, the owner loses the grant at the next edge. The new winner is picked from the other requesters only. This takes precedence over the owner's `last_beat`.
- R8: With `slot_len` equal to 0, a burst is never cut short, however long it lasts.
- R9: With no request pending and `park_sel` at 0 or 3, the grant becomes all zeros.
- R10: With no request pending and `park_sel` at 1, the grant parks on the most recently arbitrated master, or is zero if no master has ever been granted.
- R11: With no request pending and `park_sel` at 2, the grant parks on master `park_idx`. An index of 6 or 7 gives an all-zero grant.
- R12: Every arbitration win restarts the slot count at 1, including a re-grant to the same master after its burst ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 6 | Request line per master |
| last_beat | input | 6 | Per master: current beat ends its burst |
| arb_sel | input | 2 | Arbitration scheme: 1 priority, otherwise rotating |
| slot_len | input | 8 | Slot length in cycles, 0 disables the limit |
| park_sel | input | 2 | Idle policy: 0 none, 1 last master, 2 fixed master |
| park_idx | input | 3 | Fixed parking master index |
| prio_word | input | 24 | Four-bit field per master, low two bits used |
| grant | output | 6 | One-hot grant, registered |

## Verification
An expiring slot and the end of a burst can fall on the same cycle. In that cycle the owner both loses its slot and flags `last_beat`, and the two rules point toward different candidate sets. The stimulus uses slot lengths of one to four cycles and raises `last_beat` on about a quarter of the beats. Such collisions therefore occur often in both arbitration modes. The bench model judges them by excluding the owner whenever the slot has expired, so a design that lets the owner win the re-arbitration fails the check.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam logic [1:0] ARB_PRIO = 2'd1;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_RSVD  = 2'd3
  } park_e;

  // index reached after stepping 'step' places up a ring of 'n' masters
  function automatic int ring_step(int base, int step, int n);
    return (base + step) % n;
  endfunction

  // slot used up: limit non-zero and count has reached it
  function automatic logic slot_spent(int unsigned cnt, int unsigned limit);
    return (limit != 0) && (cnt >= limit);
  endfunction

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] win,
  output logic          vld
);
  // scan from the farthest offset down so the nearest requester is written last
  always_comb begin
    win = '0;
    vld = 1'b0;
    for (int off = N; off >= 1; off--) begin
      if (cand[arb_pkg::ring_step(int'(last), off, N)]) begin
        win = IW'(arb_pkg::ring_step(int'(last), off, N));
        vld = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int N      = 6,
  parameter int IW     = 3,
  parameter int PW     = 2,
  parameter int STRIDE = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    cand,
  input  logic [N*STRIDE-1:0] prio_word,
  output logic [IW-1:0]   win,
  output logic            vld
);
  logic [PW-1:0] prio [N];
  logic [PW-1:0] best;

  for (genvar g = 0; g < N; g++) begin : g_field
    assign prio[g] = prio_word[g*STRIDE +: PW];
  end

  // strict greater-than keeps the lowest index on ties
  always_comb begin
    win  = '0;
    vld  = 1'b0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!vld || prio[i] > best)) begin
        win  = IW'(i);
        best = prio[i];
        vld  = 1'b1;
      end
    end
  end

  // R4
  prio_win_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> cand[win]);
endmodule

// File: rtl/arb_slot_timer.sv
module arb_slot_timer #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          hold,
  input  logic [SW-1:0] limit,
  output logic          expired
);
  logic [SW-1:0] cnt;

  // R12: a new win restarts at 1; holding counts up and saturates
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= SW'(1);
    else if (hold && cnt != '1)   cnt <= cnt + SW'(1);
    else if (!hold)               cnt <= '0;
  end

  assign expired = arb_pkg::slot_spent(int'(cnt), int'(limit));
endmodule

// File: rtl/bus_slot_arbiter.sv
module bus_slot_arbiter #(
  parameter int NUM_MASTERS = 6,
  parameter int SLOT_W      = 8,
  parameter int PRIO_W      = 2,
  parameter int FIELD_STEP  = 4,
  parameter int PARK_W      = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_MASTERS-1:0]        req,
  input  logic [NUM_MASTERS-1:0]        last_beat,
  input  logic [1:0]                    arb_sel,
  input  logic [SLOT_W-1:0]             slot_len,
  input  logic [1:0]                    park_sel,
  input  logic [PARK_W-1:0]             park_idx,
  input  logic [NUM_MASTERS*FIELD_STEP-1:0] prio_word,
  output logic [NUM_MASTERS-1:0]        grant
);
  import arb_pkg::*;

  localparam int N  = NUM_MASTERS;
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  grant_q;
  logic          held_q;
  logic [IW-1:0] own_q;
  logic [IW-1:0] last_q;
  logic          last_vld_q;

  // named internal events
  logic [N-1:0]  own_oh;
  logic          owner_req;
  logic          others_req;
  logic          slot_over;
  logic          brk;
  logic          keep;
  logic [N-1:0]  cand;
  logic [IW-1:0] rr_win, pr_win, win;
  logic          rr_vld, pr_vld, win_vld;
  logic          new_grant;
  logic [N-1:0]  park_vec;

  assign own_oh     = N'(1) << own_q;
  assign owner_req  = held_q & req[own_q];
  assign others_req = |(req & ~own_oh);
  assign brk        = owner_req & slot_over & others_req;
  assign keep       = owner_req & ~last_beat[own_q] & ~brk;
  assign cand       = brk ? (req & ~own_oh) : req;

  arb_rr_pick #(.N(N), .IW(IW)) u_rr (
    .cand (cand),
    .last (last_q),
    .win  (rr_win),
    .vld  (rr_vld)
  );

  arb_prio_pick #(.N(N), .IW(IW), .PW(PRIO_W), .STRIDE(FIELD_STEP)) u_prio (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand      (cand),
    .prio_word (prio_word),
    .win       (pr_win),
    .vld       (pr_vld)
  );

  assign win       = (arb_sel == ARB_PRIO) ? pr_win : rr_win;
  assign win_vld   = (arb_sel == ARB_PRIO) ? pr_vld : rr_vld;
  assign new_grant = ~keep & win_vld;

  arb_slot_timer #(.SW(SLOT_W)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (new_grant),
    .hold    (keep),
    .limit   (slot_len),
    .expired (slot_over)
  );

  always_comb begin
    park_vec = '0;
    case (park_e'(park_sel))
      PARK_LAST:  if (last_vld_q) park_vec = N'(1) << last_q;
      PARK_FIXED: if (int'(park_idx) < N) park_vec = N'(1) << park_idx;
      default:    park_vec = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q    <= '0;
      held_q     <= 1'b0;
      own_q      <= '0;
      last_q     <= IW'(N - 1);
      last_vld_q <= 1'b0;
    end else if (keep) begin
      held_q     <= 1'b1;
    end else if (new_grant) begin
      grant_q    <= N'(1) << win;
      held_q     <= 1'b1;
      own_q      <= win;
      last_q     <= win;
      last_vld_q <= 1'b1;
    end else begin
      grant_q    <= park_vec;
      held_q     <= 1'b0;
    end
  end

  assign grant = grant_q;

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R6
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keep |=> $stable(grant));

  // R7
  slot_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> (grant != $past(grant)));

  // R9
  park_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0 && (park_sel == 2'd0 || park_sel == 2'd3)) |=> (grant == '0));

  // R3
  rr_win_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rr_vld |-> cand[rr_win]);
endmodule

// File: tb/sim_bus_slot_arbiter.sv
module sim_bus_slot_arbiter;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] last_beat = '0;
  logic [1:0]   arb_sel = '0;
  logic [7:0]   slot_len = '0;
  logic [1:0]   park_sel = '0;
  logic [2:0]   park_idx = '0;
  logic [23:0]  prio_word = '0;
  logic [N-1:0] grant;

  int checks = 0;
  int fails  = 0;

  // model state
  logic [N-1:0] m_grant;
  logic         m_held;
  int           m_own, m_last, m_cnt;
  logic         m_lastv;
  string        m_tag;

  always #10 clk = ~clk;

  bus_slot_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .last_beat(last_beat),
    .arb_sel(arb_sel), .slot_len(slot_len), .park_sel(park_sel),
    .park_idx(park_idx), .prio_word(prio_word), .grant(grant)
  );

  function automatic int prio_of(logic [23:0] w, int i);
    return int'((w >> (4 * i)) & 24'h3);
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: grant=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_grant = '0; m_held = 1'b0; m_own = 0; m_last = N - 1;
    m_cnt = 0; m_lastv = 1'b0; m_tag = "R1";
  endtask

  // next-state of the expected grant, from the requirements
  task automatic model_step();
    logic own_req, others, spent, brk, keep;
    logic [N-1:0] cand;
    int best, win, ties;
    own_req = m_held && req[m_own];
    others  = (req & ~(N'(1) << m_own)) != 0;
    spent   = (slot_len != 0) && (m_cnt >= int'(slot_len));
    brk     = own_req && spent && others;
    keep    = own_req && !last_beat[m_own] && !brk;
    cand    = brk ? (req & ~(N'(1) << m_own)) : req;
    if (keep) begin
      m_tag = (slot_len == 0 && others) ? "R8" : "R6";
      if (m_cnt < 255) m_cnt++;
    end else if (cand != 0) begin
      win = -1;
      if (arb_sel == 2'd1) begin
        best = -1; ties = 0;
        for (int i = 0; i < N; i++) if (cand[i] && prio_of(prio_word, i) > best) best = prio_of(prio_word, i);
        for (int i = N - 1; i >= 0; i--) if (cand[i] && prio_of(prio_word, i) == best) begin win = i; ties++; end
        m_tag = (ties > 1) ? "R5" : "R4";
      end else begin
        for (int k = 1; k <= N && win < 0; k++) if (cand[(m_last + k) % N]) win = (m_last + k) % N;
        m_tag = "R3";
      end
      if (brk) m_tag = "R7";
      else if (m_held && win == m_own) m_tag = "R12";
      m_grant = N'(1) << win; m_held = 1'b1; m_own = win; m_last = win;
      m_lastv = 1'b1; m_cnt = 1;
    end else begin
      m_held = 1'b0; m_cnt = 0;
      case (park_sel)
        2'd1: begin m_grant = m_lastv ? N'(1) << m_last : '0; m_tag = "R10"; end
        2'd2: begin m_grant = (park_idx < N) ? N'(1) << park_idx : '0; m_tag = "R11"; end
        default: begin m_grant = '0; m_tag = "R9"; end
      endcase
    end
  endtask

  task automatic cycle();
    model_step();
    @(negedge clk);
    check(m_tag, grant, m_grant);
    checks++;
    if ($countones(grant) > 1) begin
      fails++;
      $display("FAIL R2: grant=%b expected at most one bit", grant);
    end
  endtask

  task automatic random_phase(int ncyc, int req_pct, int lb_pct);
    for (int c = 0; c < ncyc; c++) begin
      for (int i = 0; i < N; i++) begin
        req[i]       = ($urandom % 100) < req_pct;
        last_beat[i] = ($urandom % 100) < lb_pct;
      end
      cycle();
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_0a17);
    model_reset();
    req = 6'b111111;
    park_sel = 2'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", grant, '0);
    rst_n = 1'b1;
    req = '0;
    check("R1", grant, '0);

    // directed: slot disabled, continuous burst with all masters waiting
    arb_sel = 2'd0; slot_len = 8'd0; park_sel = 2'd0;
    req = 6'b111111; last_beat = '0;
    for (int c = 0; c < 300; c++) cycle();

    // directed: short slot, owner flags last beat in the cycle the slot ends
    slot_len = 8'd2; last_beat = 6'b111111;
    for (int c = 0; c < 20; c++) cycle();

    // directed: fixed parking on an index with no master, then a valid one
    req = '0; last_beat = '0; park_sel = 2'd2; park_idx = 3'd7;
    cycle(); cycle();
    park_idx = 3'd4;
    cycle(); cycle();
    park_sel = 2'd1;
    cycle(); cycle();

    // directed: priority ties on all masters
    arb_sel = 2'd1; prio_word = 24'h222222; slot_len = 8'd1;
    req = 6'b101100;
    for (int c = 0; c < 8; c++) cycle();

    for (int ph = 0; ph < 24; ph++) begin
      arb_sel   = 2'($urandom % 4);
      slot_len  = (ph % 3 == 0) ? 8'd0 : 8'($urandom % 5);
      park_sel  = 2'($urandom % 4);
      park_idx  = 3'($urandom % 8);
      prio_word = 24'($urandom) & 24'h333333;
      random_phase(250, 10 + (ph % 4) * 20, 25);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule